// File: doc/BRIEF.md
# Interrupt-on-Change Controller for Two GPIO Ports

This block monitors two 8-bit general-purpose input ports and raises a per-port interrupt when an enabled pin changes. It sits behind the register file of an I/O expander. The register file supplies the per-pin enable, compare-mode, default-value and input-inversion vectors, plus three shared bits that shape the interrupt pins: mirror, open-drain and active level. The block returns the reported pin levels, a per-pin flag vector, a per-port capture snapshot and the drive controls (output enable and level) of the two interrupt pins.

Raw pin levels first pass through a two-flop synchronizer. The per-pin inversion vector is then applied to give the reported level. All comparisons and snapshots use this reported level. Each port runs a two-state machine. The states are WATCH (nothing pending; flags are zero) and HELD (interrupt pending; flags and snapshot are frozen). The arm transition moves WATCH to HELD on the first cycle that any enabled pin mismatches its reference. In that cycle the mismatching pins are written to the flags and the whole port is written to the capture register. The release transition moves HELD to WATCH when the host reads that port's capture register or data register, which the register file signals with a one-cycle strobe. If a compare-to-default mismatch still holds after the release, the arm transition fires again on the next cycle.

Top module: `ioc_irq_ctrl`

## Requirements
- R1: After reset, all flags and captures are zero and no interrupt is pending. With all shared bits at 0, both interrupt pins drive high (irq_oe = 2'b11, irq_lvl = 2'b11).
- R2: A pin whose enable bit is 0 never sets a flag or asserts an interrupt, whatever its level does.
- R3: With compare-mode bit 0, a change of an enabled pin's reported level sets its flag. The flag appears after the third rising clock edge following the pin change: two synchronizer stages, then the event register.
- R4: With compare-mode bit 1, an enabled pin whose reported level differs from its default-value bit sets its flag. The mismatch alone does this; no change is needed.
- R5: The flag vector of a port holds 1 exactly for the enabled pins that mismatched in the arming cycle, and 0 for every other pin.
- R6: On arming, the capture register of the port takes the reported level of all eight pins of that port, enabled or not.
- R7: While a port is HELD, further mismatches change neither its flags nor its capture register.
- R8: A strobe on rd_cap[p] or rd_dat[p] while port p is HELD clears its flags and deasserts its interrupt at the next edge. If a compare-to-default mismatch persists, the port re-arms one edge later.
- R9: When a pin's inversion bit is 1, its reported level (port_view) is the complement of the synchronized pin level. Comparison and capture use the reported level.
- R10: With mirror set, either port pending activates both interrupt pins. With mirror clear, each pin follows only its own port.
- R11: With open-drain clear, both pins are always driven (irq_oe = 1). Each drives the active-level bit when active and its complement when idle.
- R12: With open-drain set, irq_lvl is 0 and irq_oe equals the pin's activity, whatever the active-level bit is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 16 | Asynchronous pin levels; [7:0] port 0, [15:8] port 1 |
| cfg_en | input | 16 | Per-pin interrupt enable (1 = enabled) |
| cfg_mode | input | 16 | Per-pin compare mode (0 = previous value, 1 = default value) |
| cfg_ref | input | 16 | Per-pin default-value bits |
| cfg_inv | input | 16 | Per-pin input inversion (1 = inverted) |
| cfg_mirror | input | 1 | OR the two port interrupts onto both pins |
| cfg_odrain | input | 1 | Open-drain interrupt pins |
| cfg_actlvl | input | 1 | Active level for driven pins (0 low, 1 high) |
| rd_cap | input | 2 | Per-port capture-register read strobe |
| rd_dat | input | 2 | Per-port data-register read strobe |
| port_view | output | 16 | Reported (synchronized, inverted) pin levels |
| flags | output | 16 | Per-pin interrupt flags |
| capture | output | 16 | Per-port snapshot taken on arming |
| irq_oe | output | 2 | Interrupt pin output enable, one per port |
| irq_lvl | output | 2 | Interrupt pin driven level, one per port |

## Verification
The hardest situation to reach is a port that is already HELD seeing a second, different mismatch, because the first event must be held stable while the pins keep moving. The stimulus arms port 0 with one pin in previous-value mode, then toggles a second enabled pin and waits for it to clear the synchronizer. Only then does it issue the release strobe, and it checks that flags and snapshot still show the first event. The re-arm path after release is reached with a persistent compare-to-default mismatch. Flags are sampled in the single cycle after the strobe, and again one edge later.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
    typedef enum logic [0:0] {
        ST_WATCH = 1'b0,
        ST_HELD  = 1'b1
    } ioc_state_e;
endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/ioc_port.sv
module ioc_port
    import ioc_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] cur,
    input  logic [PORT_W-1:0] en,
    input  logic [PORT_W-1:0] mode,
    input  logic [PORT_W-1:0] ref_val,
    input  logic              clr,
    output logic [PORT_W-1:0] flags,
    output logic [PORT_W-1:0] cap,
    output logic              pending
);
    ioc_state_e        state, nxt;
    logic [PORT_W-1:0] prev;
    logic [PORT_W-1:0] hit;
    logic              fire;

    // previous-value reference follows the reported level every cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    always_comb begin
        hit  = en & ((mode & (cur ^ ref_val)) | (~mode & (cur ^ prev)));
        fire = |hit;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WATCH;
        else        state <= nxt;
    end

    // arm / release transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WATCH: if (fire) nxt = ST_HELD;
            ST_HELD:  if (clr)  nxt = ST_WATCH;
        endcase
    end

    // outputs: flags and snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            cap   <= '0;
        end else begin
            unique case (state)
                ST_WATCH: begin
                    if (fire) begin
                        flags <= hit;
                        cap   <= cur;
                    end
                end
                ST_HELD: begin
                    if (clr) flags <= '0;
                end
            endcase
        end
    end

    assign pending = (state == ST_HELD);

    // R5
    held_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD) |-> (flags != '0));
    // R5
    watch_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH) |-> (flags == '0));
    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD) |=> $stable(cap));
    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && clr) |=> (flags == '0 && !pending));
endmodule

// File: rtl/ioc_irq_drive.sv
module ioc_irq_drive #(
    parameter int NPORT = 2
) (
    input  logic [NPORT-1:0] pend,
    input  logic             mirror,
    input  logic             odrain,
    input  logic             actlvl,
    output logic [NPORT-1:0] oe,
    output logic [NPORT-1:0] lvl
);
    logic             any_pend;
    logic [NPORT-1:0] act;

    assign any_pend = |pend;

    for (genvar p = 0; p < NPORT; p++) begin : g_pin
        always_comb begin
            act[p] = mirror ? any_pend : pend[p];
            if (odrain) begin
                oe[p]  = act[p];
                lvl[p] = 1'b0;
            end else begin
                oe[p]  = 1'b1;
                lvl[p] = act[p] ? actlvl : ~actlvl;
            end
        end
    end
endmodule

// File: rtl/ioc_irq_ctrl.sv
module ioc_irq_ctrl #(
    parameter int PORT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*PORT_W-1:0]   pin_raw,
    input  logic [2*PORT_W-1:0]   cfg_en,
    input  logic [2*PORT_W-1:0]   cfg_mode,
    input  logic [2*PORT_W-1:0]   cfg_ref,
    input  logic [2*PORT_W-1:0]   cfg_inv,
    input  logic                  cfg_mirror,
    input  logic                  cfg_odrain,
    input  logic                  cfg_actlvl,
    input  logic [1:0]            rd_cap,
    input  logic [1:0]            rd_dat,
    output logic [2*PORT_W-1:0]   port_view,
    output logic [2*PORT_W-1:0]   flags,
    output logic [2*PORT_W-1:0]   capture,
    output logic [1:0]            irq_oe,
    output logic [1:0]            irq_lvl
);
    localparam int NPORT = 2;
    localparam int TOT_W = NPORT * PORT_W;

    logic [TOT_W-1:0] pin_s;
    logic [NPORT-1:0] pend;

    ioc_sync #(.WIDTH(TOT_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .q_sync  (pin_s)
    );

    assign port_view = pin_s ^ cfg_inv;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        ioc_port #(.PORT_W(PORT_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .cur     (port_view[p*PORT_W +: PORT_W]),
            .en      (cfg_en[p*PORT_W +: PORT_W]),
            .mode    (cfg_mode[p*PORT_W +: PORT_W]),
            .ref_val (cfg_ref[p*PORT_W +: PORT_W]),
            .clr     (rd_cap[p] | rd_dat[p]),
            .flags   (flags[p*PORT_W +: PORT_W]),
            .cap     (capture[p*PORT_W +: PORT_W]),
            .pending (pend[p])
        );
    end

    ioc_irq_drive #(.NPORT(NPORT)) u_drive (
        .pend   (pend),
        .mirror (cfg_mirror),
        .odrain (cfg_odrain),
        .actlvl (cfg_actlvl),
        .oe     (irq_oe),
        .lvl    (irq_lvl)
    );

    // R10
    mirror_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mirror |-> (irq_oe[0] == irq_oe[1] && irq_lvl[0] == irq_lvl[1]));
    // R11
    driven_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_odrain |-> (irq_oe == 2'b11));
    // R12
    odrain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_odrain |-> (irq_lvl == 2'b00 && $countones(irq_oe) == $countones(pend & {2{!cfg_mirror}}) + (cfg_mirror && (pend != 0) ? 2 : 0)));
endmodule

// File: tb/ioc_irq_ctrl_test.sv
`timescale 1ns/1ps
module ioc_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_raw = '0, cfg_en = '0, cfg_mode = '0, cfg_ref = '0, cfg_inv = '0;
    logic        cfg_mirror = 1'b0, cfg_odrain = 1'b0, cfg_actlvl = 1'b0;
    logic [1:0]  rd_cap = '0, rd_dat = '0;
    logic [15:0] port_view, flags, capture;
    logic [1:0]  irq_oe, irq_lvl;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    ioc_irq_ctrl #(.PORT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .cfg_en(cfg_en),
        .cfg_mode(cfg_mode), .cfg_ref(cfg_ref), .cfg_inv(cfg_inv),
        .cfg_mirror(cfg_mirror), .cfg_odrain(cfg_odrain), .cfg_actlvl(cfg_actlvl),
        .rd_cap(rd_cap), .rd_dat(rd_dat), .port_view(port_view), .flags(flags),
        .capture(capture), .irq_oe(irq_oe), .irq_lvl(irq_lvl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clear(input logic [1:0] c, input logic [1:0] d);
        rd_cap = c; rd_dat = d;
        step(1);
        rd_cap = '0; rd_dat = '0;
    endtask

    task automatic quiesce();
        cfg_en = '0; cfg_mode = '0; cfg_ref = '0; cfg_inv = '0; pin_raw = '0;
        cfg_mirror = 0; cfg_odrain = 0; cfg_actlvl = 0;
        step(4);
        pulse_clear(2'b11, 2'b00);
        step(1);
    endtask

    task automatic t_reset();
        chk("R1 flags", flags, 16'h0);
        chk("R1 capture", capture, 16'h0);
        chk("R1 irq_oe", irq_oe, 2'b11);
        chk("R1 irq_lvl", irq_lvl, 2'b11);
    endtask

    task automatic t_disabled();
        pin_raw = 16'h0404;
        step(4);
        chk("R2 flags", flags, 16'h0);
        chk("R2 irq_lvl", irq_lvl, 2'b11);
        quiesce();
    endtask

    task automatic t_prev_and_hold();
        cfg_en = 16'h000C;
        step(1);
        pin_raw = 16'h0024;
        step(2);
        chk("R3 not before third edge", flags, 16'h0);
        step(1);
        chk("R3 flag", flags, 16'h0004);
        chk("R5 only mismatching enabled pin", flags, 16'h0004);
        chk("R6 capture", capture, 16'h0024);
        chk("R11 active low port0", irq_lvl, 2'b10);
        pin_raw = 16'h002C;
        step(4);
        chk("R7 flags frozen", flags, 16'h0004);
        chk("R7 capture frozen", capture, 16'h0024);
        pulse_clear(2'b01, 2'b00);
        chk("R8 cleared by cap read", flags, 16'h0);
        chk("R8 irq idle", irq_lvl, 2'b11);
        step(1);
        chk("R8 no re-arm in prev mode", flags, 16'h0);
        pin_raw = 16'h0020;
        step(3);
        chk("R5 two pins", flags, 16'h000C);
        chk("R6 capture second", capture, 16'h0020);
        pulse_clear(2'b00, 2'b01);
        chk("R8 cleared by data read", flags, 16'h0);
        quiesce();
    endtask

    task automatic t_default();
        cfg_en = 16'h0100; cfg_mode = 16'h0100; cfg_ref = 16'h0100;
        step(3);
        chk("R4 default mismatch", flags, 16'h0100);
        chk("R6 capture port1", capture[15:8], 8'h00);
        chk("R11 port1 only", irq_lvl, 2'b01);
        pulse_clear(2'b10, 2'b00);
        chk("R8 released", flags, 16'h0);
        chk("R8 released irq", irq_lvl, 2'b11);
        step(1);
        chk("R8 re-armed", flags, 16'h0100);
        pin_raw = 16'h0100;
        step(3);
        pulse_clear(2'b10, 2'b00);
        step(2);
        chk("R4 match stays quiet", flags, 16'h0);
        quiesce();
    endtask

    task automatic t_invert();
        cfg_inv = 16'h0001;
        step(1);
        chk("R9 inverted view", port_view, 16'h0001);
        cfg_en = 16'h0001; cfg_mode = 16'h0001; cfg_ref = 16'h0000;
        step(2);
        chk("R9 compare on inverted", flags, 16'h0001);
        chk("R9 capture inverted", capture[7:0], 8'h01);
        pin_raw = 16'h0001;
        step(3);
        chk("R9 view back to zero", port_view, 16'h0000);
        quiesce();
    endtask

    task automatic t_mirror();
        cfg_mirror = 1;
        cfg_en = 16'h0001; cfg_mode = 16'h0001; cfg_ref = 16'h0001;
        step(2);
        chk("R10 both active", irq_lvl, 2'b00);
        cfg_mirror = 0;
        step(1);
        chk("R10 unmirrored", irq_lvl, 2'b10);
        quiesce();
    endtask

    task automatic t_pins();
        cfg_actlvl = 1;
        step(1);
        chk("R11 idle high-active", irq_lvl, 2'b00);
        chk("R11 driven", irq_oe, 2'b11);
        cfg_en = 16'h0001; cfg_mode = 16'h0001; cfg_ref = 16'h0001;
        step(2);
        chk("R11 active high", irq_lvl, 2'b01);
        quiesce();
        cfg_odrain = 1; cfg_actlvl = 1;
        step(1);
        chk("R12 idle released", irq_oe, 2'b00);
        cfg_en = 16'h0100; cfg_mode = 16'h0100; cfg_ref = 16'h0100;
        step(2);
        chk("R12 oe port1", irq_oe, 2'b10);
        chk("R12 level low", irq_lvl, 2'b00);
        quiesce();
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL R1 watchdog act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_disabled();
        t_prev_and_hold();
        t_default();
        t_invert();
        t_mirror();
        t_pins();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule